// File: doc/BRIEF.md
# Two-Stage Longest-Prefix Lookup Engine

The engine resolves a destination address to a forwarding result in two stages. The upper address bits select one entry of a direct-indexed front array. That entry is either the final answer for the address or a pointer to a search node. A search node is one 256-bit memory word holding five sorted 16-bit keys and eleven 16-bit pointers. Because all five keys are compared at once, each node read is a six-way branch. The walk continues from node to node until it reaches a pointer tagged as a final result.

A lookup is launched with `start_i` while `ready_o` is high. Completion is signalled by a one-cycle `done_o` pulse, with `result_o` and `err_o` valid in that cycle. Both memories are loaded through simple write ports. Building the nodes and maintaining the routes are left to the surrounding system. The front array index width is a parameter; the hardware design point is 16 bits. A maximum walk depth bounds the number of node reads, so a malformed or cyclic table ends the walk instead of hanging it.

Top module: `lpm_lookup_engine`

## Requirements
- R1: After reset, and after a reset asserted during a walk, `ready_o` is 1 and both `done_o` and `err_o` are 0.
- R2: The front array index is `addr_i[ADDR_W-1 -: IDX_W]`. A pointer with bit 15 set is a final result, and `result_o` is its bits 14:0. If the array entry is a final result, `done_o` rises one clock after the accepting edge with `err_o` 0. A rewritten array entry takes effect on the next lookup.
- R3: A pointer with bit 15 clear names a node by its low `NODE_AW` bits. In a node word, key i (i=0..4) is at bits [16i+15:16i], equal pointer i is at [80+16i+15:80+16i], and range pointer j (j=0..5) is at [160+16j+15:160+16j].
- R4: The node search key is `addr_i[ADDR_W-IDX_W-1 -: 16]`, and the same key is used at every node. If the key equals key i, the engine follows equal pointer i.
- R5: If the key lies strictly between key i-1 and key i, the engine follows range pointer i. A key below key 0 follows range pointer 0, and a key above key 4 follows range pointer 5.
- R6: Each node read adds one clock. A result found in the n-th node makes `done_o` rise n+1 clocks after the accepting edge, and n+1 never exceeds MAX_DEPTH+1.
- R7: If the pointer chosen in the MAX_DEPTH-th node is still a node pointer, the walk ends with `done_o` and `err_o` both 1 and `result_o` 0.
- R8: `start_i` is ignored while `ready_o` is 0. A lookup in flight returns its own result, and the ignored request produces no completion.
- R9: `done_o` is high for exactly one cycle. `result_o` holds its value until the next completion.
- R10: When several equal keys in a node match, the lowest-indexed equal pointer is followed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arr_we_i | input | 1 | Front array write enable |
| arr_waddr_i | input | IDX_W | Front array write index |
| arr_wdata_i | input | 16 | Front array entry (tagged pointer) |
| node_we_i | input | 1 | Node memory write enable |
| node_waddr_i | input | NODE_AW | Node memory write address |
| node_wdata_i | input | 256 | Node word |
| start_i | input | 1 | Launch a lookup when ready |
| addr_i | input | ADDR_W | Address to resolve |
| ready_o | output | 1 | Engine idle, will accept start_i |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Depth limit reached (with done_o) |
| result_o | output | 15 | Final result payload |

## Verification
The assertions assume that `start_i` and `addr_i` are driven away from the clock edge, that the memories are not rewritten while a walk reads them, and that keys within every node are non-decreasing. The bench fills both memories through the write ports before any lookup and never writes during a walk. The node chain it builds is sorted, including a node with duplicate keys. One deliberately cyclic pointer in that chain exercises the depth bound, so the bounded-walk property holds by the design and not by luck of the data.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int KEY_W    = 16;
  localparam int PTR_W    = 16;
  localparam int NKEYS    = 5;
  localparam int NRANGE   = NKEYS + 1;
  localparam int NSLOTS   = NKEYS + NKEYS + NRANGE;
  localparam int NODE_W   = KEY_W * NSLOTS;
  localparam int EQ_BASE  = NKEYS * KEY_W;
  localparam int RNG_BASE = 2 * NKEYS * KEY_W;
  localparam int RES_W    = PTR_W - 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARR,
    ST_NODE
  } walk_state_e;
endpackage

// File: rtl/lpm_index_array.sv
module lpm_index_array #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/lpm_node_mem.sv
module lpm_node_mem #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/lpm_node_select.sv
// Single-cycle six-way branch: parallel compare of the key against all node keys.
module lpm_node_select
  import lpm_pkg::*;
(
  input  logic [NODE_W-1:0] node_i,
  input  logic [KEY_W-1:0]  key_i,
  output logic [PTR_W-1:0]  ptr_o
);
  localparam int CNT_W = $clog2(NRANGE);

  logic [NKEYS-1:0]  eq_hit;
  logic [NKEYS-1:0]  below;
  logic [PTR_W-1:0]  eq_ptr   [NKEYS];
  logic [PTR_W-1:0]  rng_ptr  [NRANGE];

  for (genvar i = 0; i < NKEYS; i++) begin : g_cmp
    logic [KEY_W-1:0] k;
    assign k          = node_i[i*KEY_W +: KEY_W];
    assign eq_hit[i]  = (key_i == k);
    assign below[i]   = (k < key_i);
    assign eq_ptr[i]  = node_i[EQ_BASE + i*KEY_W +: PTR_W];
  end

  for (genvar j = 0; j < NRANGE; j++) begin : g_rng
    assign rng_ptr[j] = node_i[RNG_BASE + j*KEY_W +: PTR_W];
  end

  logic [CNT_W-1:0] n_below;
  logic [PTR_W-1:0] eq_sel;

  always_comb begin
    n_below = '0;
    for (int i = 0; i < NKEYS; i++) n_below = n_below + CNT_W'(below[i]);
  end

  // Lowest matching index wins on duplicate keys.
  always_comb begin
    eq_sel = '0;
    for (int i = NKEYS - 1; i >= 0; i--) begin
      if (eq_hit[i]) eq_sel = eq_ptr[i];
    end
  end

  assign ptr_o = (|eq_hit) ? eq_sel : rng_ptr[n_below];
endmodule

// File: rtl/lpm_lookup_engine.sv
module lpm_lookup_engine
  import lpm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 8,
  parameter int NODE_DEPTH = 64,
  parameter int MAX_DEPTH  = 4,
  localparam int NODE_AW   = $clog2(NODE_DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               arr_we_i,
  input  logic [IDX_W-1:0]   arr_waddr_i,
  input  logic [PTR_W-1:0]   arr_wdata_i,
  input  logic               node_we_i,
  input  logic [NODE_AW-1:0] node_waddr_i,
  input  logic [NODE_W-1:0]  node_wdata_i,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               ready_o,
  output logic               done_o,
  output logic               err_o,
  output logic [RES_W-1:0]   result_o
);
  localparam int DEPTH_W = $clog2(MAX_DEPTH + 1);
  localparam int KEY_MSB = ADDR_W - IDX_W - 1;

  walk_state_e        state_q;
  logic [KEY_W-1:0]   key_q;
  logic [DEPTH_W-1:0] depth_q;
  logic               done_q, err_q;
  logic [RES_W-1:0]   result_q;

  logic [PTR_W-1:0]   arr_rdata;
  logic [NODE_W-1:0]  node_rdata;
  logic [PTR_W-1:0]   sel_ptr;
  logic [PTR_W-1:0]   cur_ptr;
  logic               accept, is_info, at_limit, node_re;

  assign accept   = start_i && (state_q == ST_IDLE);
  assign cur_ptr  = (state_q == ST_ARR) ? arr_rdata : sel_ptr;
  assign is_info  = cur_ptr[PTR_W-1];
  assign at_limit = (state_q == ST_NODE) && (depth_q == DEPTH_W'(MAX_DEPTH));
  assign node_re  = (state_q != ST_IDLE) && !is_info && !at_limit;

  lpm_index_array #(
    .IDX_W (IDX_W),
    .DATA_W(PTR_W)
  ) u_arr (
    .clk_i  (clk_i),
    .we_i   (arr_we_i),
    .waddr_i(arr_waddr_i),
    .wdata_i(arr_wdata_i),
    .re_i   (accept),
    .raddr_i(addr_i[ADDR_W-1 -: IDX_W]),
    .rdata_o(arr_rdata)
  );

  lpm_node_mem #(
    .DEPTH (NODE_DEPTH),
    .DATA_W(NODE_W)
  ) u_nodes (
    .clk_i  (clk_i),
    .we_i   (node_we_i),
    .waddr_i(node_waddr_i),
    .wdata_i(node_wdata_i),
    .re_i   (node_re),
    .raddr_i(cur_ptr[NODE_AW-1:0]),
    .rdata_o(node_rdata)
  );

  lpm_node_select u_sel (
    .node_i(node_rdata),
    .key_i (key_q),
    .ptr_o (sel_ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      key_q    <= '0;
      depth_q  <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            key_q   <= addr_i[KEY_MSB -: KEY_W];
            state_q <= ST_ARR;
          end
        end
        ST_ARR: begin
          if (is_info) begin
            result_q <= cur_ptr[RES_W-1:0];
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            depth_q <= DEPTH_W'(1);
            state_q <= ST_NODE;
          end
        end
        ST_NODE: begin
          if (is_info) begin
            result_q <= cur_ptr[RES_W-1:0];
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end else if (at_limit) begin
            result_q <= '0;
            done_q   <= 1'b1;
            err_q    <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            depth_q <= depth_q + DEPTH_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o  = (state_q == ST_IDLE);
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign result_o = result_q;
endmodule

// File: rtl/lpm_walk_checker.sv
module lpm_walk_checker #(
  parameter int MAX_DEPTH = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic ready_o,
  input logic done_o,
  input logic err_o
);
  logic [15:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       busy_cnt <= '0;
    else if (done_o)   busy_cnt <= '0;
    else if (!ready_o) busy_cnt <= busy_cnt + 16'd1;
  end

  assert_bounded_walk_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt <= 16'(MAX_DEPTH + 1));

  assert_err_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  assert_busy_after_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o) |=> !ready_o);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_when_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);
endmodule

bind lpm_lookup_engine lpm_walk_checker #(.MAX_DEPTH(MAX_DEPTH)) u_walk_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .ready_o(ready_o),
  .done_o (done_o),
  .err_o  (err_o)
);

// File: tb/tb_lpm_lookup_engine.sv
`timescale 1ns/1ps
module tb_lpm_lookup_engine;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 8;
  localparam int NDEP   = 64;
  localparam int MAXD   = 4;
  localparam int NAW    = $clog2(NDEP);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic arr_we_i = 1'b0;
  logic [IDX_W-1:0] arr_waddr_i = '0;
  logic [15:0] arr_wdata_i = '0;
  logic node_we_i = 1'b0;
  logic [NAW-1:0] node_waddr_i = '0;
  logic [255:0] node_wdata_i = '0;
  logic start_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic ready_o, done_o, err_o;
  logic [14:0] result_o;

  int checks = 0;
  int fails = 0;
  int cycle_cnt = 0;

  always #2.5 clk_i = ~clk_i;

  lpm_lookup_engine #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .NODE_DEPTH(NDEP), .MAX_DEPTH(MAXD)
  ) dut (.*);

  always @(posedge clk_i) begin
    cycle_cnt <= cycle_cnt + 1;
    if (cycle_cnt > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycle_cnt);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Vector table: idx 0x02 walks the node chain; key in addr[23:8].
  localparam int NV = 13;
  localparam logic [31:0] V_ADDR [NV] = '{
    32'h01_0000_00, 32'h02_3000_00, 32'h02_0FFF_00, 32'h02_2500_00,
    32'h02_1000_00, 32'h02_5000_00, 32'h02_4FFF_00, 32'h02_7800_00,
    32'h02_A000_00, 32'h02_C000_00, 32'h02_B000_00, 32'h02_FFF0_00,
    32'h02_FFFF_00};
  localparam logic [14:0] V_RES [NV] = '{
    15'h011, 15'h0E2, 15'h0A0, 15'h0A2, 15'h0E0, 15'h0E4, 15'h0A4,
    15'h0C2, 15'h0B4, 15'h0D0, 15'h0F0, 15'h1D0, 15'h000};
  localparam logic V_ERR [NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,1};
  localparam int V_LAT [NV] = '{1,2,2,2,2,2,2,3,3,4,4,5,5};
  localparam string V_REQ [NV] = '{
    "R2", "R4", "R5", "R5", "R4", "R4", "R5", "R6", "R6", "R10", "R5", "R10", "R7"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_arr(input logic [IDX_W-1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    arr_we_i = 1'b1; arr_waddr_i = a; arr_wdata_i = d;
    @(negedge clk_i);
    arr_we_i = 1'b0;
  endtask

  // Packed fields, index 0 in the low bits: keys, equal ptrs, range ptrs (R3).
  task automatic write_node(input logic [NAW-1:0] a, input logic [79:0] k,
                            input logic [79:0] e, input logic [95:0] r);
    @(negedge clk_i);
    node_we_i = 1'b1; node_waddr_i = a; node_wdata_i = {r, e, k};
    @(negedge clk_i);
    node_we_i = 1'b0;
  endtask

  function automatic logic [79:0] info5(input logic [14:0] base);
    logic [79:0] v;
    for (int i = 0; i < 5; i++) v[i*16 +: 16] = {1'b1, base + 15'(i)};
    return v;
  endfunction

  function automatic logic [95:0] rng6(input logic [14:0] base, input logic [15:0] last);
    logic [95:0] v;
    for (int j = 0; j < 5; j++) v[j*16 +: 16] = {1'b1, base + 15'(j)};
    v[80 +: 16] = last;
    return v;
  endfunction

  task automatic lookup(input logic [31:0] a, output logic [14:0] res,
                        output logic er, output int lat);
    @(negedge clk_i);
    start_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 40) begin
      @(negedge clk_i);
      lat = lat + 1;
    end
    res = result_o;
    er  = err_o;
  endtask

  initial begin
    logic [14:0] res;
    logic er;
    int lat;

    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1", {31'd0, ready_o}, 32'd1);
    check("R1", {30'd0, done_o, err_o}, 32'd0);
    rst_ni = 1'b1;

    write_arr(8'h01, 16'h8011);
    write_arr(8'h02, 16'h0001);
    // R3: node 1..4 chain; last range pointer links to the next node
    write_node(6'd1, {16'h5000, 16'h4000, 16'h3000, 16'h2000, 16'h1000},
               info5(15'h0E0), rng6(15'h0A0, 16'h0002));
    write_node(6'd2, {16'hA000, 16'h9000, 16'h8000, 16'h7000, 16'h6000},
               info5(15'h0B0), rng6(15'h0C0, 16'h0003));
    write_node(6'd3, {16'hF000, 16'hE000, 16'hD000, 16'hC000, 16'hC000},
               info5(15'h0D0), rng6(15'h0F0, 16'h0004));
    write_node(6'd4, {16'hFFF0, 16'hFFF0, 16'hFFF0, 16'hFFF0, 16'hFFF0},
               info5(15'h1D0), rng6(15'h1E0, 16'h0001));

    for (int v = 0; v < NV; v++) begin
      lookup(V_ADDR[v], res, er, lat);
      check(V_REQ[v], {17'd0, res}, {17'd0, V_RES[v]});
      check(V_REQ[v], {31'd0, er}, {31'd0, V_ERR[v]});
      check("R6", lat, V_LAT[v]);
    end

    // R9: one-cycle pulse, result held
    lookup(32'h02_3000_00, res, er, lat);
    @(negedge clk_i);
    check("R9", {31'd0, done_o}, 32'd0);
    check("R9", {17'd0, result_o}, 32'h0E2);

    // R8: start while busy is ignored
    @(negedge clk_i);
    start_i = 1'b1; addr_i = 32'h02_FFF0_00;
    @(negedge clk_i);
    addr_i = 32'h01_0000_00;
    check("R8", {31'd0, ready_o}, 32'd0);
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 40) begin
      @(negedge clk_i);
      lat = lat + 1;
    end
    check("R8", {17'd0, result_o}, 32'h1D0);
    check("R8", lat, 5);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk_i);
      check("R8", {31'd0, done_o}, 32'd0);
    end

    // R2: rewritten array entry takes effect
    write_arr(8'h01, 16'h8077);
    lookup(32'h01_1234_00, res, er, lat);
    check("R2", {17'd0, res}, 32'h077);
    check("R2", lat, 1);

    // R1: reset during a walk
    @(negedge clk_i);
    start_i = 1'b1; addr_i = 32'h02_FFFF_00;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1", {31'd0, ready_o}, 32'd1);
    check("R1", {30'd0, done_o, err_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (6) begin
      @(negedge clk_i);
      check("R1", {31'd0, done_o}, 32'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule